// File: doc/BRIEF.md
# Multi-target SPI byte master

This block is a mode-0 SPI master that lives entirely in one system clock domain. It divides the system clock down to a serial clock and moves one byte at a time over MOSI and MISO. Bytes arrive on a valid/ready stream that carries three things with each byte: the data, a target index and an end-of-burst flag. The target index picks which of several active-low select lines goes low.

A burst is a run of bytes sent under one select assertion. The select stays low from the first byte until a byte flagged as the end of the burst has been shifted. Between bytes of a burst the serial clock rests low and the block waits for the next byte. While the burst lasts, the target index of later bytes has no effect.

Each byte is shifted MSB first. While it goes out, the block captures a byte from MISO and presents it on the receive port with a single-cycle strobe. The receive port has no backpressure.

Top module: `spi_burst_master`

## Requirements
- R1: During and after a synchronous active-high reset, all select lines are high, SCLK is low, MOSI is low, the receive strobe is low and ready is high.
- R2: SCLK is low whenever no byte is being shifted. Each SCLK half-period lasts exactly HALF = SYS_CLK_HZ/(2*SER_CLK_HZ) system cycles, using integer division. The first rising edge of a byte comes HALF cycles after the cycle in which the byte was accepted.
- R3: At most one select line is low at any time. When a byte is accepted while idle, the line whose index equals the binary target address goes low in the next cycle. An address with no matching line leaves every line high.
- R4: A byte is accepted at a clock edge where valid and ready are both high. Ready goes low in the cycle after acceptance and stays low until the SCLK fall that ends the byte's eighth bit.
- R5: Data bits leave MSB first. MOSI carries bit 7 from the cycle after acceptance and changes only together with a falling SCLK, never in a cycle in which SCLK rises.
- R6: MISO is sampled at each rising SCLK, with the first sample taken as bit 7. The receive strobe is high for exactly one cycle: the first cycle in which SCLK is high for the eighth time. In that cycle the receive data holds the assembled byte.
- R7: After a byte without the end flag, the select stays low, SCLK stays low and ready is high until the next byte is accepted. That byte's first rising edge then follows its acceptance by HALF cycles.
- R8: After a byte with the end flag, every select line is high in the cycle after its eighth SCLK fall. Ready then stays low for HALF more cycles before the block returns to idle.
- R9: The target address is captured only when a byte is accepted while idle. Addresses presented with later bytes of the same burst are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | N_TARGETS | Active-low select, one line per target |
| mosi_o | output | 1 | Serial data to the targets |
| miso_i | input | 1 | Serial data from the targets |
| tgt_i | input | SEL_W | Target index for a new burst |
| tx_data_i | input | WORD_W | Byte to send |
| tx_last_i | input | 1 | Marks the final byte of a burst |
| tx_valid_i | input | 1 | Byte on the input is valid |
| tx_ready_o | output | 1 | Block can take a byte |
| rx_data_o | output | WORD_W | Byte received from MISO |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
The serial outputs become due at fixed offsets from acceptance. The select line and MOSI change one cycle after acceptance. Each SCLK edge then follows after another HALF cycles. The receive strobe appears together with the eighth SCLK rise, 15·HALF cycles after acceptance. After an end-flagged byte, ready returns 17·HALF cycles after acceptance.

The bench runs its own cycle-level model, built from integer counters, on the same clock edge as the design, and compares every output with that model at the following falling edge. Because both sides are registered on the same edge and compared half a cycle later, every result is checked in the exact cycle it is due. A separate target model collects MOSI bits at each SCLK rise and serves MISO bits, so it checks byte order, target selection and received data without reference to the model's timing.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_HOLD  = 2'd2,
      ST_TRAIL = 2'd3
   } bm_state_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/spi_bm_tick.sv
module spi_bm_tick #(
   parameter int HALF = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt_q;

   assign tick = run && (cnt_q == CW'(HALF - 1));

   always_ff @(posedge clk) begin
      if (rst || !run || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R2: the count never passes the half-period limit
   p_cnt_limit_r2: assert property (@(posedge clk) disable iff (rst)
      run |-> (cnt_q <= CW'(HALF - 1)));

endmodule

// File: rtl/spi_bm_shift.sv
module spi_bm_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         advance,
   input  logic         capture,
   input  logic         serial_in,
   output logic         serial_out,
   output logic [W-1:0] rx
);
   logic [W-1:0] tx_q;
   logic [W-1:0] rx_q;

   always_ff @(posedge clk) begin
      if (rst)          tx_q <= '0;
      else if (load)    tx_q <= din;
      else if (advance) tx_q <= {tx_q[W-2:0], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (rst)          rx_q <= '0;
      else if (capture) rx_q <= {rx_q[W-2:0], serial_in};
   end

   assign serial_out = tx_q[W-1];
   assign rx         = rx_q;

   // R5: a load and a shift never coincide
   p_no_load_shift_r5: assert property (@(posedge clk) disable iff (rst)
      !(load && advance));

endmodule

// File: rtl/spi_bm_csel.sv
module spi_bm_csel #(
   parameter int N  = 1,
   parameter int SW = 1
) (
   input  logic          en,
   input  logic [SW-1:0] sel,
   output logic [N-1:0]  cs_n
);
   for (genvar i = 0; i < N; i++) begin : g_line
      assign cs_n[i] = ~(en && (sel == SW'(i)));
   end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_bm_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int SER_CLK_HZ = 2_000_000,
   parameter int N_TARGETS  = 1,
   parameter int WORD_W     = 8,
   localparam int SEL_W     = sel_width(N_TARGETS)
) (
   input  logic                 clk,
   input  logic                 rst,
   output logic                 sclk_o,
   output logic [N_TARGETS-1:0] cs_n_o,
   output logic                 mosi_o,
   input  logic                 miso_i,
   input  logic [SEL_W-1:0]     tgt_i,
   input  logic [WORD_W-1:0]    tx_data_i,
   input  logic                 tx_last_i,
   input  logic                 tx_valid_i,
   output logic                 tx_ready_o,
   output logic [WORD_W-1:0]    rx_data_o,
   output logic                 rx_valid_o
);
   localparam int HALF = SYS_CLK_HZ / (2 * SER_CLK_HZ);
   localparam int BW   = $clog2(WORD_W + 1);

   initial begin : chk_params
      assert (SER_CLK_HZ * 10 <= SYS_CLK_HZ)
         else $error("serial clock must be at most a tenth of the system clock");
      assert (N_TARGETS >= 1) else $error("need at least one target");
      assert (WORD_W >= 2)    else $error("word must have at least two bits");
   end

   bm_state_e          state_q;
   logic [BW-1:0]      bitn_q;
   logic               last_q;
   logic [SEL_W-1:0]   sel_q;
   logic               sclk_q;
   logic               vld_q;
   logic [WORD_W-1:0]  dout_q;

   logic               tick;
   logic               accept;
   logic               rise;
   logic               fall;
   logic [WORD_W-1:0]  rx_w;
   logic               sel_en;

   assign tx_ready_o = (state_q == ST_IDLE) || (state_q == ST_HOLD);
   assign accept     = tx_valid_i && tx_ready_o;
   assign rise       = (state_q == ST_SHIFT) && tick && !sclk_q;
   assign fall       = (state_q == ST_SHIFT) && tick && sclk_q;
   assign sel_en     = (state_q == ST_SHIFT) || (state_q == ST_HOLD);

   spi_bm_tick #(.HALF(HALF)) tick_i (
      .clk  (clk),
      .rst  (rst),
      .run  ((state_q == ST_SHIFT) || (state_q == ST_TRAIL)),
      .tick (tick)
   );

   spi_bm_shift #(.W(WORD_W)) shift_i (
      .clk        (clk),
      .rst        (rst),
      .load       (accept),
      .din        (tx_data_i),
      .advance    (fall),
      .capture    (rise),
      .serial_in  (miso_i),
      .serial_out (mosi_o),
      .rx         (rx_w)
   );

   spi_bm_csel #(.N(N_TARGETS), .SW(SEL_W)) csel_i (
      .en   (sel_en),
      .sel  (sel_q),
      .cs_n (cs_n_o)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         bitn_q  <= '0;
         last_q  <= 1'b0;
         sel_q   <= '0;
         sclk_q  <= 1'b0;
         vld_q   <= 1'b0;
         dout_q  <= '0;
      end else begin
         vld_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  sel_q   <= tgt_i;
                  last_q  <= tx_last_i;
                  bitn_q  <= '0;
                  state_q <= ST_SHIFT;
               end
            end
            ST_HOLD: begin
               if (accept) begin
                  last_q  <= tx_last_i;
                  bitn_q  <= '0;
                  state_q <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (rise) begin
                  sclk_q <= 1'b1;
                  bitn_q <= bitn_q + 1'b1;
                  if (bitn_q == BW'(WORD_W - 1)) begin
                     vld_q  <= 1'b1;
                     dout_q <= {rx_w[WORD_W-2:0], miso_i};
                  end
               end else if (fall) begin
                  sclk_q <= 1'b0;
                  if (bitn_q == BW'(WORD_W))
                     state_q <= last_q ? ST_TRAIL : ST_HOLD;
               end
            end
            ST_TRAIL: begin
               if (tick) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk_o     = sclk_q;
   assign rx_valid_o = vld_q;
   assign rx_data_o  = dout_q;

   // R3: never more than one select line low
   p_one_sel_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~cs_n_o));

   // R2: no serial clock outside a byte
   p_sclk_rest_r2: assert property (@(posedge clk) disable iff (rst)
      ((state_q == ST_IDLE) || (state_q == ST_TRAIL) || (state_q == ST_HOLD)) |-> !sclk_o);

   // R4: acceptance closes the handshake for the next cycle
   p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (rst)
      (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

   // R5: MOSI holds still across a rising serial edge
   p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (sclk_o && !$past(sclk_o)) |-> $stable(mosi_o));

   // R6: receive strobe coincides with a fresh rising serial edge
   p_strobe_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
      rx_valid_o |-> (sclk_o && !$past(sclk_o)));

   // R6: strobe is a single-cycle pulse
   p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
      rx_valid_o |=> !rx_valid_o);

   // R7: a held select keeps the same line low
   p_sel_steady_r7: assert property (@(posedge clk) disable iff (rst)
      (!(&cs_n_o) && !(&$past(cs_n_o))) |-> $stable(cs_n_o));

   // R9: the captured target stays put for the whole burst
   p_tgt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> $stable(sel_q));

endmodule

// File: tb/spi_burst_master_tb.sv
module spi_burst_master_tb_top;
   localparam int SYS  = 100_000_000;
   localparam int SER  = 10_000_000;
   localparam int NT   = 4;
   localparam int WW   = 8;
   localparam int HALF = SYS / (2 * SER);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sclk_o;
   logic [NT-1:0] cs_n_o;
   logic          mosi_o;
   logic          miso_i = 1'b0;
   logic [1:0]    tgt_i = '0;
   logic [WW-1:0] tx_data_i = '0;
   logic          tx_last_i = 1'b0;
   logic          tx_valid_i = 1'b0;
   logic          tx_ready_o;
   logic [WW-1:0] rx_data_o;
   logic          rx_valid_o;

   always #5 clk = ~clk;

   spi_burst_master #(
      .SYS_CLK_HZ(SYS), .SER_CLK_HZ(SER), .N_TARGETS(NT), .WORD_W(WW)
   ) dut_i (
      .clk(clk), .rst(rst), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
      .miso_i(miso_i), .tgt_i(tgt_i), .tx_data_i(tx_data_i), .tx_last_i(tx_last_i),
      .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o),
      .rx_valid_o(rx_valid_o)
   );

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: phase 0 idle, 1 shifting, 2 between bytes, 3 trailing gap
   int        m_ph, m_cnt, m_bits, m_sel;
   bit        m_last, m_sclk, m_vld, m_ready;
   bit [7:0]  m_tx, m_rx, m_dout;

   always @(posedge clk) begin
      bit acc;
      acc = tx_valid_i && m_ready;
      if (rst) begin
         m_ph = 0; m_cnt = 0; m_bits = 0; m_sel = 0; m_last = 0;
         m_sclk = 0; m_vld = 0; m_ready = 1; m_tx = 0; m_rx = 0; m_dout = 0;
      end else begin
         m_vld = 0;
         case (m_ph)
            0: if (acc) begin
                  m_sel = tgt_i; m_last = tx_last_i; m_tx = tx_data_i;
                  m_bits = 0; m_cnt = 0; m_ph = 1;
               end
            1: if (m_cnt == HALF - 1) begin
                  m_cnt = 0;
                  if (!m_sclk) begin
                     m_sclk = 1; m_rx = {m_rx[6:0], miso_i}; m_bits++;
                     if (m_bits == 8) begin m_vld = 1; m_dout = m_rx; end
                  end else begin
                     m_sclk = 0; m_tx = m_tx << 1;
                     if (m_bits == 8) m_ph = m_last ? 3 : 2;
                  end
               end else m_cnt++;
            2: if (acc) begin
                  m_last = tx_last_i; m_tx = tx_data_i;
                  m_bits = 0; m_cnt = 0; m_ph = 1;
               end
            default: if (m_cnt == HALF - 1) begin m_cnt = 0; m_ph = 0; end
                     else m_cnt++;
         endcase
         m_ready = (m_ph == 0) || (m_ph == 2);
      end
   end

   always @(negedge clk) begin
      logic [NT-1:0] m_cs;
      if (cmp_on && !rst) begin
         m_cs = ((m_ph == 1) || (m_ph == 2)) ? ~(NT'(1) << m_sel) : '1;
         chk(sclk_o == m_sclk, "R2 sclk", sclk_o, m_sclk);
         chk(cs_n_o == m_cs, "R3 R7 R8 select", cs_n_o, m_cs);
         chk(tx_ready_o == m_ready, "R4 R7 R8 ready", tx_ready_o, m_ready);
         chk(mosi_o == m_tx[7], "R5 mosi", mosi_o, m_tx[7]);
         chk(rx_valid_o == m_vld, "R6 strobe", rx_valid_o, m_vld);
         if (m_vld) chk(rx_data_o == m_dout, "R6 model data", rx_data_o, m_dout);
      end
   end

   // target-side model and end-to-end byte checks
   bit [7:0] resp_q[$];
   bit [7:0] exp_tx_q[$];
   bit [7:0] exp_rx_q[$];
   int       exp_tg_q[$];
   int       sbit = 0;
   bit [7:0] sh = 0;
   bit       ps = 0;

   always @(negedge clk) begin
      if (rst) begin
         sbit = 0; ps = 0; miso_i = 1'b0;
      end else begin
         if (&cs_n_o) sbit = 0;
         else if (sclk_o && !ps) begin
            sh = {sh[6:0], mosi_o};
            sbit++;
            if (sbit == 8) begin
               int low_idx;
               low_idx = -1;
               for (int i = 0; i < NT; i++) if (!cs_n_o[i]) low_idx = i;
               if (exp_tx_q.size() > 0) begin
                  bit [7:0] e;
                  int t;
                  e = exp_tx_q.pop_front();
                  t = exp_tg_q.pop_front();
                  chk(sh == e, "R5 byte at target", sh, e);
                  chk(low_idx == t, "R3 R9 target line", low_idx, t);
               end else chk(1'b0, "R5 unexpected byte", sh, 0);
               if (resp_q.size() > 0) void'(resp_q.pop_front());
               sbit = 0;
            end
         end
         if (!sclk_o) miso_i = (resp_q.size() > 0) ? resp_q[0][7 - sbit] : 1'b0;
         ps = sclk_o;
         if (rx_valid_o) begin
            if (exp_rx_q.size() > 0) begin
               bit [7:0] r;
               r = exp_rx_q.pop_front();
               chk(rx_data_o == r, "R6 received byte", rx_data_o, r);
            end else chk(1'b0, "R6 unexpected strobe", rx_data_o, 0);
         end
      end
   end

   int burst_tgt = 0;
   bit in_burst  = 0;

   task automatic send(input int tgt, input bit [7:0] d, input bit [7:0] r,
                       input bit last, input int gap);
      int eff;
      repeat (gap) @(negedge clk);
      eff = in_burst ? burst_tgt : tgt;
      if (!in_burst) burst_tgt = tgt;
      in_burst = !last;
      resp_q.push_back(r);
      exp_tx_q.push_back(d);
      exp_rx_q.push_back(r);
      exp_tg_q.push_back(eff);
      tgt_i      = 2'(tgt);
      tx_data_i  = d;
      tx_last_i  = last;
      tx_valid_i = 1'b1;
      while (!tx_ready_o) @(negedge clk);
      @(negedge clk);
      tx_valid_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", cyc, 50000);
         finish_run();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: state held under reset
      chk(cs_n_o == '1, "R1 select in reset", cs_n_o, 4'hF);
      chk(sclk_o == 1'b0, "R1 sclk in reset", sclk_o, 0);
      rst = 1'b0;
      @(negedge clk);
      chk(cs_n_o == '1, "R1 select after reset", cs_n_o, 4'hF);
      chk(sclk_o == 1'b0, "R1 sclk after reset", sclk_o, 0);
      chk(tx_ready_o == 1'b1, "R1 ready after reset", tx_ready_o, 1);
      chk(rx_valid_o == 1'b0, "R1 strobe after reset", rx_valid_o, 0);
      chk(mosi_o == 1'b0, "R1 mosi after reset", mosi_o, 0);
      cmp_on = 1'b1;

      // single byte, end flag set
      send(2, 8'hA5, 8'h3C, 1'b1, 2);
      // back-to-back burst with address changes after the first byte (R9)
      send(1, 8'h81, 8'hC3, 1'b0, 3);
      send(3, 8'h7E, 8'h18, 1'b0, 0);
      send(0, 8'hFF, 8'h00, 1'b1, 0);
      // burst with a long pause between bytes (R7)
      send(0, 8'h00, 8'hFF, 1'b0, 1);
      send(0, 8'h5A, 8'hA5, 1'b1, 20);
      // byte offered at once, waits through the trailing gap (R8)
      send(3, 8'h01, 8'h80, 1'b1, 0);
      send(1, 8'h80, 8'h01, 1'b1, 0);

      repeat (30 * HALF) @(negedge clk);
      chk(exp_tx_q.size() == 0, "R5 all bytes delivered", exp_tx_q.size(), 0);
      chk(exp_rx_q.size() == 0, "R6 all bytes returned", exp_rx_q.size(), 0);
      chk(cs_n_o == '1, "R8 select released at end", cs_n_o, 4'hF);
      done = 1'b1;
      finish_run();
   end

endmodule